// File: doc/BRIEF.md
# Four-Channel Output Compare Timer

This block runs a 16-bit up-counter that advances on each qualified clock tick and compares it against four 16-bit compare values. When a channel that is configured for output compare sees its compare value while the counter ticks, the channel raises its flag and applies a programmed action to its own pin. The actions are toggle, clear, set or no change. Software can also trigger the same action with a force write, and a force never raises a flag.

Channel 3 has an extra role. Through a mask and a data register it can preset any of the four pins to fixed levels. For every masked pin this preset overrides whatever channels 0 to 2 do in the same cycle. All state is reached over a byte-wide register bus. Reads on that bus are combinational, and writes take effect at the clock edge.

Top module: `cmp4_timer`

## Requirements
- R1: The counter resets to 0. It increments by one on every rising edge where `tickEn` is 1 and holds otherwise. Its high byte reads at address 0x00 and its low byte at 0x01. Channel n's compare value has its high byte at 0x02+2n and its low byte at 0x03+2n, and resets to 0.
- R2: A real match on channel n happens at an edge where `tickEn` is 1, the counter equals compare n, and select bit n (address 0x0A, bit n, 1 = output compare) is set. After that edge flag n (address 0x0F, bit n) reads 1 and the channel's action has been applied.
- R3: Each channel's action is a 2-bit field at address 0x0B, bits [2n+1:2n]. The codes are 00 = no change, 01 = toggle, 10 = drive 0 and 11 = drive 1. Pin levels read at address 0x11 and reset to 0.
- R4: Writing address 0x0C with bit n set applies channel n's action at that edge, but only when select bit n is set. It never sets flag n.
- R5: If a force and a real match hit the same channel at the same edge, the action is applied once and the flag stays 0.
- R6: When channel 3 matches or is forced, every pin n whose mask bit (address 0x0E, bit n) is 1 takes data bit n (address 0x0D, bit n). This wins over any channel 0 to 2 action at that edge.
- R7: A pin whose mask bit is 0 is not changed by a channel 3 event.
- R8: `pinOe[n]` is 1 exactly when select bit n is set and either mask bit n is 1 or the action code of channel n is not 00. The enable bits also read at address 0x12.
- R9: The mask and data registers reset to 0. Only bits 3:0 are stored, and bits 7:4 read as 0.
- R10: Address 0x0C always reads 0.
- R11: Writing 1 to a flag bit clears it, and writing 0 has no effect. Interrupt enables sit at address 0x10, bits 3:0. `irq` is 1 when any flag is set together with its enable.
- R12: A channel whose select bit is 0 never matches, never sets its flag, and ignores force writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Counter advance qualifier |
| regAddr | input | 5 | Register address |
| regWe | input | 1 | Register write enable |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational) |
| pinOut | output | 4 | Compare pin levels |
| pinOe | output | 4 | Per-pin output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The toggle, clear and set codes are each driven by force writes while the counter is frozen. This shows that every code moves the pin in its own direction and that no flag rises. The bench then fires channel 3 with a mask that covers a toggling channel and with a mask of 0, which separates the override from the pass-through. Single-tick counter pulses against compare values equal to the current count cover a real match, a match on a deselected channel, a match that lands together with a force, and a joint channel 0 and channel 3 match. Together these tell the flag rules apart from the pin rules.

// File: rtl/cmp4_pkg.sv
package cmp4_pkg;
  localparam int NCH    = 4;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;
  localparam int ACT_W  = 2;

  localparam logic [ADDR_W-1:0] A_CNT_HI   = 5'h00;
  localparam logic [ADDR_W-1:0] A_CNT_LO   = 5'h01;
  localparam int                A_CMP_BASE = 2;
  localparam logic [ADDR_W-1:0] A_IOSEL    = 5'h0A;
  localparam logic [ADDR_W-1:0] A_ACT      = 5'h0B;
  localparam logic [ADDR_W-1:0] A_FORCE    = 5'h0C;
  localparam logic [ADDR_W-1:0] A_DATA3    = 5'h0D;
  localparam logic [ADDR_W-1:0] A_MASK3    = 5'h0E;
  localparam logic [ADDR_W-1:0] A_FLAG     = 5'h0F;
  localparam logic [ADDR_W-1:0] A_IRQEN    = 5'h10;
  localparam logic [ADDR_W-1:0] A_PIN      = 5'h11;
  localparam logic [ADDR_W-1:0] A_OE       = 5'h12;

  typedef enum logic [ACT_W-1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } act_e;

  typedef struct packed {
    logic [NCH-1:0][CNT_W-1:0] cmpVal;
    logic [NCH-1:0]            ioSel;
    logic [NCH-1:0][ACT_W-1:0] action;
    logic [NCH-1:0]            mask3;
    logic [NCH-1:0]            data3;
    logic [NCH-1:0]            irqEn;
  } cfg_t;

  typedef struct packed {
    logic [NCH-1:0] forceHit;
    logic [NCH-1:0] flagClr;
  } stb_t;
endpackage

// File: rtl/cmp4_ctrl.sv
module cmp4_ctrl
  import cmp4_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic                   regWe,
  input  logic [DATA_W-1:0]      regWdata,
  output logic [DATA_W-1:0]      regRdata,
  input  logic [CNT_W-1:0]       cnt,
  input  logic [NCH-1:0]         flags,
  input  logic [NCH-1:0]         pinQ,
  input  logic [NCH-1:0]         pinOe,
  output cfg_t                   cfg,
  output stb_t                   stb
);
  localparam int PAD_W = DATA_W - NCH;

  logic [NCH-1:0][CNT_W-1:0] cmpQ;
  logic [NCH-1:0]            ioSelQ;
  logic [NCH-1:0][ACT_W-1:0] actQ;
  logic [NCH-1:0]            maskQ;
  logic [NCH-1:0]            dataQ;
  logic [NCH-1:0]            irqEnQ;

  // one-cycle strobes toward the datapath
  always_comb begin
    stb.forceHit = (regWe && regAddr == A_FORCE) ? regWdata[NCH-1:0] : '0;
    stb.flagClr  = (regWe && regAddr == A_FLAG)  ? regWdata[NCH-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ioSelQ <= '0;
      actQ   <= '0;
      maskQ  <= '0;
      dataQ  <= '0;
      irqEnQ <= '0;
    end else if (regWe) begin
      case (regAddr)
        A_IOSEL: ioSelQ <= regWdata[NCH-1:0];
        A_ACT:   actQ   <= regWdata[NCH*ACT_W-1:0];
        A_MASK3: maskQ  <= regWdata[NCH-1:0];
        A_DATA3: dataQ  <= regWdata[NCH-1:0];
        A_IRQEN: irqEnQ <= regWdata[NCH-1:0];
        default: ;
      endcase
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_cmp
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(A_CMP_BASE + 2*n);
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(A_CMP_BASE + 2*n + 1);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cmpQ[n] <= '0;
      end else if (regWe && regAddr == HI_A) begin
        cmpQ[n][CNT_W-1:DATA_W] <= regWdata;
      end else if (regWe && regAddr == LO_A) begin
        cmpQ[n][DATA_W-1:0] <= regWdata;
      end
    end
  end

  assign cfg.cmpVal = cmpQ;
  assign cfg.ioSel  = ioSelQ;
  assign cfg.action = actQ;
  assign cfg.mask3  = maskQ;
  assign cfg.data3  = dataQ;
  assign cfg.irqEn  = irqEnQ;

  always_comb begin
    regRdata = '0;
    case (regAddr)
      A_CNT_HI: regRdata = cnt[CNT_W-1:DATA_W];
      A_CNT_LO: regRdata = cnt[DATA_W-1:0];
      A_IOSEL:  regRdata = {{PAD_W{1'b0}}, ioSelQ};
      A_ACT:    regRdata = actQ;
      A_MASK3:  regRdata = {{PAD_W{1'b0}}, maskQ};
      A_DATA3:  regRdata = {{PAD_W{1'b0}}, dataQ};
      A_FLAG:   regRdata = {{PAD_W{1'b0}}, flags};
      A_IRQEN:  regRdata = {{PAD_W{1'b0}}, irqEnQ};
      A_PIN:    regRdata = {{PAD_W{1'b0}}, pinQ};
      A_OE:     regRdata = {{PAD_W{1'b0}}, pinOe};
      default:  regRdata = '0;
    endcase
    for (int n = 0; n < NCH; n++) begin
      if (regAddr == ADDR_W'(A_CMP_BASE + 2*n))     regRdata = cmpQ[n][CNT_W-1:DATA_W];
      if (regAddr == ADDR_W'(A_CMP_BASE + 2*n + 1)) regRdata = cmpQ[n][DATA_W-1:0];
    end
  end
endmodule

// File: rtl/cmp4_datapath.sv
module cmp4_datapath
  import cmp4_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  cfg_t             cfg,
  input  stb_t             stb,
  output logic [CNT_W-1:0] cnt,
  output logic [NCH-1:0]   flags,
  output logic [NCH-1:0]   pinQ,
  output logic [NCH-1:0]   pinOe,
  output logic             irq
);
  localparam int OVR_CH = NCH - 1;

  logic [NCH-1:0] matchHit;
  logic [NCH-1:0] forceOk;
  logic [NCH-1:0] chEvt;
  logic [NCH-1:0] pinNext;

  always_ff @(posedge clk) begin
    if (!rstN)       cnt <= '0;
    else if (tickEn) cnt <= cnt + 1'b1;
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign matchHit[n] = tickEn && cfg.ioSel[n] && (cnt == cfg.cmpVal[n]);
    assign forceOk[n]  = stb.forceHit[n] && cfg.ioSel[n];
    assign chEvt[n]    = matchHit[n] || forceOk[n];
    assign pinOe[n]    = cfg.ioSel[n] && (cfg.mask3[n] || (cfg.action[n] != ACT_NONE));
  end

  always_comb begin
    for (int n = 0; n < NCH; n++) begin
      pinNext[n] = pinQ[n];
      if (chEvt[n]) begin
        case (act_e'(cfg.action[n]))
          ACT_TOGGLE: pinNext[n] = ~pinQ[n];
          ACT_CLEAR:  pinNext[n] = 1'b0;
          ACT_SET:    pinNext[n] = 1'b1;
          default:    pinNext[n] = pinQ[n];
        endcase
      end
      if (chEvt[OVR_CH] && cfg.mask3[n]) pinNext[n] = cfg.data3[n];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinQ  <= '0;
      flags <= '0;
    end else begin
      pinQ  <= pinNext;
      flags <= (flags & ~stb.flagClr) | (matchHit & ~stb.forceHit);
    end
  end

  assign irq = |(flags & cfg.irqEn);
endmodule

// File: rtl/cmp4_timer.sv
module cmp4_timer
  import cmp4_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic [NCH-1:0]    pinOut,
  output logic [NCH-1:0]    pinOe,
  output logic              irq
);
  cfg_t             cfg;
  stb_t             stb;
  logic [CNT_W-1:0] cnt;
  logic [NCH-1:0]   flags;

  cmp4_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .cnt(cnt), .flags(flags),
    .pinQ(pinOut), .pinOe(pinOe), .cfg(cfg), .stb(stb)
  );

  cmp4_datapath dp_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cfg(cfg), .stb(stb),
    .cnt(cnt), .flags(flags), .pinQ(pinOut), .pinOe(pinOe), .irq(irq)
  );
endmodule

// File: rtl/cmp4_timer_chk.sv
module cmp4_timer_chk
  import cmp4_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWe,
  input logic [DATA_W-1:0] regWdata,
  input logic [DATA_W-1:0] regRdata,
  input logic [NCH-1:0]    pinOut,
  input logic [NCH-1:0]    pinOe,
  input logic              irq,
  input logic [CNT_W-1:0]  cnt,
  input logic [NCH-1:0]    flags,
  input cfg_t              cfg
);
  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    tickEn |=> cnt == CNT_W'($past(cnt) + 1'b1));
  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(cnt));
  // R8
  oe_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pinOe & ~cfg.ioSel) == '0);
  // R10
  force_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == A_FORCE) |-> regRdata == '0);
  // R11
  irq_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (flags & cfg.irqEn) != '0);
  // R6
  ovr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && cfg.ioSel[NCH-1] && cnt == cfg.cmpVal[NCH-1])
      |=> (pinOut & $past(cfg.mask3)) == ($past(cfg.data3) & $past(cfg.mask3)));

  for (genvar n = 0; n < NCH; n++) begin : g_chk
    // R4 R5
    force_noflag_chk: assert property (@(posedge clk) disable iff (!rstN)
      (regWe && regAddr == A_FORCE && regWdata[n]) |=> !$rose(flags[n]));
    // R12
    flag_src_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(flags[n]) |-> $past(tickEn && cfg.ioSel[n]));
  end
endmodule

bind cmp4_timer cmp4_timer_chk chk_i (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .regAddr(regAddr), .regWe(regWe),
  .regWdata(regWdata), .regRdata(regRdata), .pinOut(pinOut), .pinOe(pinOe),
  .irq(irq), .cnt(cnt), .flags(flags), .cfg(cfg)
);

// File: tb/cmp4_timer_tb_top.sv
`timescale 1ns/1ps
module cmp4_timer_tb_top;
  localparam logic [4:0] T_CNTHI = 5'h00, T_CNTLO = 5'h01, T_IOSEL = 5'h0A,
                         T_ACT = 5'h0B, T_FORCE = 5'h0C, T_DATA = 5'h0D,
                         T_MASK = 5'h0E, T_FLAG = 5'h0F, T_IRQEN = 5'h10,
                         T_PIN = 5'h11, T_OE = 5'h12;
  localparam int NV = 35;
  // {write, requirement, address, data-or-expected}
  localparam logic [17:0] VEC [NV] = '{
    {1'b0, 4'd9,  T_MASK,  8'h00},  // R9 reset
    {1'b0, 4'd9,  T_DATA,  8'h00},  // R9 reset
    {1'b0, 4'd3,  T_PIN,   8'h00},  // R3 reset pins
    {1'b0, 4'd1,  T_CNTLO, 8'h00},  // R1 reset count
    {1'b1, 4'd9,  T_MASK,  8'hFF},
    {1'b0, 4'd9,  T_MASK,  8'h0F},  // R9 upper bits
    {1'b1, 4'd9,  T_DATA,  8'hF0},
    {1'b0, 4'd9,  T_DATA,  8'h00},  // R9 upper bits
    {1'b1, 4'd9,  T_MASK,  8'h00},
    {1'b1, 4'd8,  T_IOSEL, 8'h0F},
    {1'b1, 4'd3,  T_ACT,   8'h39},
    {1'b0, 4'd8,  T_OE,    8'h07},  // R8
    {1'b1, 4'd4,  T_FORCE, 8'h07},
    {1'b0, 4'd3,  T_PIN,   8'h05},  // R3 toggle/clear/set
    {1'b0, 4'd10, T_FORCE, 8'h00},  // R10
    {1'b0, 4'd4,  T_FLAG,  8'h00},  // R4 no flag
    {1'b1, 4'd3,  T_FORCE, 8'h01},
    {1'b0, 4'd3,  T_PIN,   8'h04},  // R3 toggle back
    {1'b1, 4'd6,  T_MASK,  8'h09},
    {1'b0, 4'd8,  T_OE,    8'h0F},  // R8 mask enables pin 3
    {1'b1, 4'd6,  T_DATA,  8'h08},
    {1'b1, 4'd6,  T_FORCE, 8'h08},
    {1'b0, 4'd6,  T_PIN,   8'h0C},  // R6
    {1'b1, 4'd6,  T_DATA,  8'h00},
    {1'b1, 4'd6,  T_FORCE, 8'h09},
    {1'b0, 4'd6,  T_PIN,   8'h04},  // R6 beats ch0 toggle
    {1'b1, 4'd7,  T_MASK,  8'h00},
    {1'b1, 4'd7,  T_DATA,  8'h0F},
    {1'b1, 4'd7,  T_FORCE, 8'h08},
    {1'b0, 4'd7,  T_PIN,   8'h04},  // R7
    {1'b1, 4'd12, T_IOSEL, 8'h0E},
    {1'b1, 4'd12, T_FORCE, 8'h01},
    {1'b0, 4'd12, T_PIN,   8'h04},  // R12 force ignored
    {1'b0, 4'd8,  T_OE,    8'h06},  // R8
    {1'b1, 4'd8,  T_IOSEL, 8'h00}
  };

  logic clk = 1'b0, rstN = 1'b0, tickEn = 1'b0, regWe = 1'b0;
  logic [4:0] regAddr = '0;
  logic [7:0] regWdata = '0, regRdata;
  logic [3:0] pinOut, pinOe;
  logic irq;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cmp4_timer dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .pinOut(pinOut), .pinOe(pinOe),
    .irq(irq)
  );

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic chk(input string req, input logic [4:0] a, input logic [7:0] exp);
    @(negedge clk); regAddr = a; #1;
    checks++;
    if (regRdata !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, a, regRdata, exp);
    end
  endtask

  task automatic chkBit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic tickOnce();
    @(negedge clk); tickEn = 1'b1;
    @(negedge clk); tickEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1; chkBit("R11 reset irq", irq, 1'b0);
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][17]) wr(VEC[i][12:8], VEC[i][7:0]);
      else chk($sformatf("R%0d vec%0d", VEC[i][16:13], i), VEC[i][12:8], VEC[i][7:0]);
    end
    // R1 five ticks with all channels deselected
    @(negedge clk); tickEn = 1'b1;
    repeat (5) @(negedge clk);
    tickEn = 1'b0;
    chk("R1", T_CNTLO, 8'h05);
    chk("R1", T_CNTHI, 8'h00);
    // R2 real match on ch0 (toggle) at count 5
    wr(8'h02, 8'h00); wr(8'h03, 8'h05);
    wr(T_IRQEN, 8'h01); wr(T_IOSEL, 8'h01);
    tickOnce();
    chk("R2", T_FLAG, 8'h01);
    chk("R2", T_PIN, 8'h05);
    #1; chkBit("R11 irq", irq, 1'b1);
    // R11 write-one-to-clear
    wr(T_FLAG, 8'h00);
    chk("R11 zero write", T_FLAG, 8'h01);
    wr(T_FLAG, 8'h01);
    chk("R11 clear", T_FLAG, 8'h00);
    #1; chkBit("R11 irq low", irq, 1'b0);
    // R12 deselected ch1 matching at count 6
    wr(T_IOSEL, 8'h00); wr(8'h05, 8'h06);
    tickOnce();
    chk("R12", T_FLAG, 8'h00);
    chk("R12", T_PIN, 8'h05);
    // R5 force and match together on ch1 (toggle) at count 7
    wr(T_ACT, 8'h35); wr(8'h05, 8'h07); wr(T_IOSEL, 8'h02);
    @(negedge clk); tickEn = 1'b1; regWe = 1'b1; regAddr = T_FORCE; regWdata = 8'h02;
    @(negedge clk); tickEn = 1'b0; regWe = 1'b0;
    chk("R5", T_PIN, 8'h07);
    chk("R5", T_FLAG, 8'h00);
    // R6 joint real match ch0 and ch3 at count 8
    wr(8'h03, 8'h08); wr(8'h09, 8'h08);
    wr(T_MASK, 8'h01); wr(T_DATA, 8'h01); wr(T_IOSEL, 8'h09);
    tickOnce();
    chk("R6", T_PIN, 8'h07);
    chk("R2", T_FLAG, 8'h09);
    chk("R8", T_OE, 8'h01);
    chk("R1", T_CNTLO, 8'h09);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule